// File: doc/BRIEF.md
# Warp Hazard Gate

This block sits between instruction fetch and issue for a single warp. Fetched instructions enter a short in-order queue. Each one carries up to two source register ids, one optional destination register id and an opaque tag. A small table of pending destination registers tracks the writes that are still in flight. The oldest queued instruction is offered for issue only when none of its enabled register ids is held in that table.

An issued instruction that writes a register claims a free table slot. A writeback notice on its own port frees the slot holding that id, and the freed slot counts in the same cycle's hazard check. When the queue is full, the block lowers its fetch-ready signal so that fetch holds back. Both the fetch side and the issue side use a valid/ready handshake. The queue depth, the table size and the register-id width are parameters.

Top module: `warp_hazard_gate`

## Requirements
- R1: After reset the queue and the pending table are empty: fetch_ready is 1 and iss_valid is 0.
- R2: Instructions leave in the order they were accepted. iss_tag, iss_dst and iss_dst_en show the oldest queued instruction, and only that one can issue.
- R3: iss_valid stays 0 while any enabled source or destination id of the oldest instruction equals an id held in the pending table.
- R4: When wb_valid is 1, the entry equal to wb_rid is freed at the clock edge. In that same cycle the entry no longer counts for the hazard check or for table fullness.
- R5: When every table slot is held after this cycle's writeback, an oldest instruction with iss_dst_en=1 cannot issue. An instruction with no destination can still issue.
- R6: Issuing an instruction with iss_dst_en=0 claims no table slot.
- R7: fetch_ready is 0 exactly when the queue holds DEPTH instructions. A fetch_valid pulse while fetch_ready is 0 is not accepted.
- R8: A writeback whose id is not in the table changes nothing.
- R9: Issuing an instruction with iss_dst_en=1 (iss_valid and iss_ready both 1) places iss_dst in the table from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_ready | output | 1 | Queue can accept (low = stall) |
| fetch_tag | input | TAG_W | Opaque instruction tag |
| fetch_src0 | input | RID_W | First source register id |
| fetch_src0_en | input | 1 | First source in use |
| fetch_src1 | input | RID_W | Second source register id |
| fetch_src1_en | input | 1 | Second source in use |
| fetch_dst | input | RID_W | Destination register id |
| fetch_dst_en | input | 1 | Instruction writes a register |
| iss_valid | output | 1 | Oldest instruction is free to issue |
| iss_ready | input | 1 | Execution accepts the instruction |
| iss_tag | output | TAG_W | Tag of the oldest instruction |
| iss_dst | output | RID_W | Destination id of the oldest instruction |
| iss_dst_en | output | 1 | Oldest instruction writes a register |
| wb_valid | input | 1 | A pending write has completed |
| wb_rid | input | RID_W | Register id of the completed write |

## Verification
In a single cycle, a writeback can free a slot while the oldest instruction is checked and possibly issued, and that issue may claim the slot just freed. Directed sequences set this up in two ways. In one, a reader waits behind a pending id and the writeback for that id arrives in the cycle it is checked. In the other, the table is full and a waiting writer gains a slot from a same-cycle writeback. Random traffic uses only eight register ids, so collisions happen often. A bench model applies the clear before the hazard and fullness test, and every cycle's iss_valid, fetch_ready and head fields are compared against that model.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int unsigned DEF_RID_W = 6;
  localparam int unsigned DEF_TAG_W = 8;

  // width of one queued instruction: tag + three ids + three enables
  function automatic int unsigned entry_w(input int unsigned rid_w, input int unsigned tag_w);
    return tag_w + 3 * rid_w + 3;
  endfunction

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsb_ibuf.sv
module wsb_ibuf #(
  parameter int unsigned W     = 29,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         head_vld,
  output logic         full
);
  localparam int unsigned PTR_W = wsb_pkg::idx_w(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign dout     = slots[rd_ptr];
  assign head_vld = (cnt != '0);
  assign full     = (cnt == CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= din;
        wr_ptr        <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAP); // R7
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> cnt == $past(cnt) - 1'b1); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> head_vld); // R2
endmodule

// File: rtl/wsb_track.sv
module wsb_track #(
  parameter int unsigned RID_W   = 6,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned NQ      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_en,
  input  logic [RID_W-1:0]    clr_rid,
  input  logic                ins_en,
  input  logic [RID_W-1:0]    ins_rid,
  input  logic [NQ-1:0]       q_en,
  input  logic [NQ*RID_W-1:0] q_rid,
  output logic                hazard,
  output logic                full
);
  localparam int unsigned IDX_W = wsb_pkg::idx_w(ENTRIES);

  logic [ENTRIES-1:0] occ, live, clr_hit, occ_n;
  logic [RID_W-1:0]   ids [ENTRIES];
  logic [IDX_W-1:0]   slot;

  function automatic logic [IDX_W-1:0] first_free(input logic [ENTRIES-1:0] l);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!l[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic holds(input logic [RID_W-1:0] r);
    logic h;
    h = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (occ[i] && ids[i] == r) h = 1'b1;
    return h;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_clr
    assign clr_hit[g] = clr_en && occ[g] && (ids[g] == clr_rid);
  end

  assign live = occ & ~clr_hit;
  assign full = &live;
  assign slot = first_free(live);

  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = 0; j < NQ; j++)
        if (live[i] && q_en[j] && ids[i] == q_rid[j*RID_W +: RID_W]) hazard = 1'b1;
  end

  always_comb begin
    occ_n = live;
    if (ins_en) occ_n[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < ENTRIES; i++) ids[i] <= '0;
    end else begin
      occ <= occ_n;
      if (ins_en) ids[slot] <= ins_rid;
    end
  end

  AST_INSERT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> holds($past(ins_rid))); // R9
  AST_CLEAR_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(ins_en && ins_rid == clr_rid)) |=> !holds($past(clr_rid))); // R4
  AST_NO_INSERT_FULL: assert property (@(posedge clk) disable iff (!rst_n) ins_en |-> !full); // R5
  AST_CLEAR_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clr_hit)); // R8
endmodule

// File: rtl/warp_hazard_gate.sv
module warp_hazard_gate #(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned SB_ENTRIES = 4,
  parameter int unsigned RID_W      = wsb_pkg::DEF_RID_W,
  parameter int unsigned TAG_W      = wsb_pkg::DEF_TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [RID_W-1:0] fetch_src0,
  input  logic             fetch_src0_en,
  input  logic [RID_W-1:0] fetch_src1,
  input  logic             fetch_src1_en,
  input  logic [RID_W-1:0] fetch_dst,
  input  logic             fetch_dst_en,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [TAG_W-1:0] iss_tag,
  output logic [RID_W-1:0] iss_dst,
  output logic             iss_dst_en,
  input  logic             wb_valid,
  input  logic [RID_W-1:0] wb_rid
);
  localparam int unsigned EW = wsb_pkg::entry_w(RID_W, TAG_W);

  logic [EW-1:0]    in_word, head_word;
  logic             head_vld, q_full, push, pop;
  logic [RID_W-1:0] h_src0, h_src1;
  logic             h_src0_en, h_src1_en;
  logic             sb_hazard, sb_full, writer_blocked, ins_en;

  assign in_word = {fetch_tag, fetch_src0_en, fetch_src0, fetch_src1_en, fetch_src1,
                    fetch_dst_en, fetch_dst};
  assign {iss_tag, h_src0_en, h_src0, h_src1_en, h_src1, iss_dst_en, iss_dst} = head_word;

  assign fetch_ready    = !q_full;
  assign push           = fetch_valid && fetch_ready;
  assign writer_blocked = sb_full && iss_dst_en;
  assign iss_valid      = head_vld && !sb_hazard && !writer_blocked;
  assign pop            = iss_valid && iss_ready;
  assign ins_en         = pop && iss_dst_en;

  wsb_ibuf #(.W(EW), .DEPTH(DEPTH)) u_ibuf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_word), .pop(pop),
    .dout(head_word), .head_vld(head_vld), .full(q_full)
  );

  wsb_track #(.RID_W(RID_W), .ENTRIES(SB_ENTRIES), .NQ(3)) u_track (
    .clk(clk), .rst_n(rst_n), .clr_en(wb_valid), .clr_rid(wb_rid),
    .ins_en(ins_en), .ins_rid(iss_dst),
    .q_en({h_src0_en, h_src1_en, iss_dst_en}),
    .q_rid({h_src0, h_src1, iss_dst}),
    .hazard(sb_hazard), .full(sb_full)
  );

  AST_NO_ISSUE_ON_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    sb_hazard |-> !iss_valid); // R3
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !push) |=> head_vld && iss_tag == $past(iss_tag)); // R2
  AST_STALL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push); // R7
endmodule

// File: tb/warp_hazard_gate_test.sv
module warp_hazard_gate_test;
  localparam int DEPTH = 4, SBN = 4, RID_W = 6, TAG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, fetch_src0_en = 0, fetch_src1_en = 0, fetch_dst_en = 0;
  logic [TAG_W-1:0] fetch_tag = '0;
  logic [RID_W-1:0] fetch_src0 = '0, fetch_src1 = '0, fetch_dst = '0, wb_rid = '0;
  logic iss_ready = 0, wb_valid = 0;
  logic fetch_ready, iss_valid, iss_dst_en;
  logic [TAG_W-1:0] iss_tag;
  logic [RID_W-1:0] iss_dst;

  int checks = 0, errors = 0;
  logic [TAG_W-1:0] tagc = '0;

  // model state
  logic [TAG_W-1:0] q_tag [64];
  logic [RID_W-1:0] q_s0 [64], q_s1 [64], q_d [64];
  logic             q_s0e [64], q_s1e [64], q_de [64];
  int qh = 0, qn = 0;
  logic [63:0] pend = '0;
  int pcnt = 0;

  always #2 clk = ~clk;

  warp_hazard_gate #(.DEPTH(DEPTH), .SB_ENTRIES(SBN), .RID_W(RID_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_tag(fetch_tag), .fetch_src0(fetch_src0), .fetch_src0_en(fetch_src0_en),
    .fetch_src1(fetch_src1), .fetch_src1_en(fetch_src1_en), .fetch_dst(fetch_dst),
    .fetch_dst_en(fetch_dst_en), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .iss_dst(iss_dst), .iss_dst_en(iss_dst_en),
    .wb_valid(wb_valid), .wb_rid(wb_rid)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic bit model_hazard(input logic [63:0] p, input int i);
    return (q_s0e[i] && p[q_s0[i]]) || (q_s1e[i] && p[q_s1[i]]) || (q_de[i] && p[q_d[i]]);
  endfunction

  task automatic step(input bit fv, input int s0, input bit s0e, input int s1, input bit s1e,
                      input int d, input bit de, input bit ir, input bit wv, input int wr,
                      input string note);
    logic [63:0] pa;
    int ca;
    bit exp_rdy, exp_v, ff, fi;
    @(negedge clk);
    fetch_valid = fv; fetch_tag = tagc;
    fetch_src0 = RID_W'(s0); fetch_src0_en = s0e;
    fetch_src1 = RID_W'(s1); fetch_src1_en = s1e;
    fetch_dst = RID_W'(d); fetch_dst_en = de;
    iss_ready = ir; wb_valid = wv; wb_rid = RID_W'(wr);
    #1;
    pa = pend; ca = pcnt;
    if (wv && pend[wr]) begin pa[wr] = 1'b0; ca--; end
    exp_rdy = (qn < DEPTH);
    exp_v = 1'b0;
    if (qn > 0) exp_v = !model_hazard(pa, qh) && !(ca == SBN && q_de[qh]);
    chk(fetch_ready == exp_rdy, {"R7 fetch_ready ", note}, fetch_ready, exp_rdy);
    chk(iss_valid == exp_v, {"R3 R4 R5 R9 iss_valid ", note}, iss_valid, exp_v);
    if (qn > 0) begin
      chk(iss_tag == q_tag[qh], {"R2 iss_tag ", note}, iss_tag, q_tag[qh]);
      chk(iss_dst_en == q_de[qh], {"R2 iss_dst_en ", note}, iss_dst_en, q_de[qh]);
    end
    ff = fv && exp_rdy;
    fi = exp_v && ir;
    pend = pa; pcnt = ca;
    if (fi) begin
      if (q_de[qh]) begin pend[q_d[qh]] = 1'b1; pcnt++; end
      qh = (qh + 1) % 64; qn--;
    end
    if (ff) begin
      q_tag[(qh+qn)%64] = tagc;
      q_s0[(qh+qn)%64] = RID_W'(s0); q_s0e[(qh+qn)%64] = s0e;
      q_s1[(qh+qn)%64] = RID_W'(s1); q_s1e[(qh+qn)%64] = s1e;
      q_d[(qh+qn)%64] = RID_W'(d); q_de[(qh+qn)%64] = de;
      qn++;
    end
    if (fv) tagc = tagc + 1'b1;
  endtask

  task automatic idle(input bit ir, input bit wv, input int wr, input string note);
    step(0, 0, 0, 0, 0, 0, 0, ir, wv, wr, note);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1 fetch_ready after reset", fetch_ready, 1);
    chk(iss_valid == 1'b0, "R1 iss_valid after reset", iss_valid, 0);

    // R3/R4: reader waits on pending r3, released by same-cycle writeback
    step(1, 0, 0, 0, 0, 3, 1, 0, 0, 0, "writer r3");
    idle(1, 0, 0, "issue writer r3");
    step(1, 3, 1, 0, 0, 0, 0, 1, 0, 0, "reader r3 fetched");
    idle(1, 0, 0, "R3 reader held");
    idle(1, 1, 3, "R4 same-cycle clear releases reader");
    idle(1, 0, 0, "drain");

    // R5/R6/R8: fill the table, then a writer blocks, a non-writer passes
    for (int k = 0; k < SBN; k++) begin
      step(1, 0, 0, 0, 0, 10 + k, 1, 0, 0, 0, "fill writer");
      idle(1, 0, 0, "R9 issue fill writer");
    end
    step(1, 0, 0, 0, 0, 20, 0, 0, 0, 0, "R6 no-dst instr");
    idle(1, 0, 0, "R5 R6 no-dst passes with table full");
    step(1, 0, 0, 0, 0, 21, 1, 0, 0, 0, "writer r21");
    idle(1, 0, 0, "R5 writer blocked when full");
    idle(1, 1, 30, "R8 wb of absent id");
    idle(1, 0, 0, "R8 writer still blocked");
    idle(1, 1, 10, "R4 R5 freed slot used same cycle");
    for (int k = 11; k < 14; k++) idle(1, 1, k, "clear");
    idle(1, 1, 21, "clear r21");

    // R7: fill the queue with issue stalled, then drain in order
    for (int k = 0; k < DEPTH + 2; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 fill queue");
    for (int k = 0; k < DEPTH + 1; k++) idle(1, 0, 0, "R2 drain order");

    // random traffic on a small id space
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 3) != 0, $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2,
           $urandom % 8, ($urandom % 3) != 0, ($urandom % 4) != 0,
           ($urandom % 2) == 0, $urandom % 8, "random");
    end
    for (int k = 0; k < 8; k++) idle(1, 1, k, "final clear");
    for (int k = 0; k < DEPTH + 1; k++) idle(1, 0, 0, "final drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule